// File: doc/BRIEF.md
# Stub Cache-Controller Register File

This block gives software the register interface of an outer-level cache controller when no cache is present. Boot code and drivers can probe an identification word and a cache-type word. They can program the enable, the auxiliary settings, the tag and data latencies and an address-filter range, and they can start maintenance operations. Every maintenance operation reports as already finished. No storage or traffic filtering sits behind the registers.

Access uses a plain single-cycle register bus with an address, a read strobe, a write strobe and 32-bit data in each direction. Only the low 12 bits of the address are decoded, so the block fills a 4 KiB window. The cache-type word is built on each read from the way-size and associativity fields of the auxiliary register. Bits it sets stay set until reset. An access to an offset the block does not know returns zero, changes nothing and raises a one-cycle error pulse.

Top module: `ccstub_top`

## Requirements
- R1: A read of offset 0x000 returns 0x410000C8. A write there changes nothing.
- R2: A write to offset 0x100 (control) keeps only bit 0 and clears bits 31:1.
- R3: Offsets 0x104 (auxiliary), 0x108 (tag latency), 0x10C (data latency), 0xC00 (filter start) and 0xC04 (filter end) are full 32-bit read/write registers.
- R4: Synchronous active-high reset clears control, both latency registers and both filter registers. It loads the auxiliary register with 0x02020000 and the cache-type word with the TYPE_INIT parameter (default 0x1C100100).
- R5: Any offset in 0x730 to 0x7FF reads 0, ignores writes and raises no error. Offsets 0x72C and 0x800 are outside this range.
- R6: A read of offset 0x004 builds a 5-bit value v. Bits 4:2 of v are auxiliary bits 19:17, bit 1 is 0, and bit 0 is auxiliary bit 16. The block ORs v<<18 and v<<6 into the stored cache-type word, stores the result and returns it.
- R7: A cache-type bit once set stays set across later reads, even after the auxiliary register is cleared.
- R8: Offsets 0xF40, 0xF60 and 0xF80 read 0, ignore writes and raise no error.
- R9: Any other offset reads 0 and ignores writes. A write to 0x000 or 0x004 also counts as unknown. Each such access drives bad_access high for exactly the cycle after the strobe.
- R10: Address bits above bit 11 are ignored, so the register window aliases.
- R11: rd_data carries the read result in the cycle after rd_en is sampled and is 0 in a cycle that follows no read. A write takes effect at the edge where wr_en is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte address; only bits 11:0 are decoded |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle pulse after an access to an unknown offset |

## Verification
The bench probes both edges of the maintenance range, 0x72C, 0x730, 0x7FC and 0x800. A design with an off-by-one bound would either raise a false error at 0x7FC or treat 0x800 as a silent hole. The cache-type word is read before and after the auxiliary register is cleared. A design that recomputed the word on each read would lose the accumulated bits, and one that dropped the bit-1 gap would place the associativity bits in the wrong spots. The bench writes control with all ones to catch a design that keeps more than bit 0. It writes through an alias address with high bits set to catch a design that decodes the full address. It also checks that the error pulse lasts exactly one cycle and that writes to the read-only words still flag.

// File: rtl/ccstub_pkg.sv
package ccstub_pkg;

    localparam int OFS_W  = 12;
    localparam int WORD_W = 32;

    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t ID_WORD   = 32'h410000C8;
    localparam word_t AUX_RESET = 32'h02020000;

    localparam ofs_t OFS_ID     = 12'h000;
    localparam ofs_t OFS_TYPE   = 12'h004;
    localparam ofs_t OFS_CTRL   = 12'h100;
    localparam ofs_t OFS_AUX    = 12'h104;
    localparam ofs_t OFS_TAG    = 12'h108;
    localparam ofs_t OFS_DATA   = 12'h10C;
    localparam ofs_t OFS_FSTART = 12'hC00;
    localparam ofs_t OFS_FEND   = 12'hC04;
    localparam ofs_t MAINT_LO   = 12'h730;
    localparam ofs_t MAINT_HI   = 12'h800;   // exclusive
    localparam ofs_t OFS_QUIET0 = 12'hF40;
    localparam ofs_t OFS_QUIET1 = 12'hF60;
    localparam ofs_t OFS_QUIET2 = 12'hF80;

    // shift positions of the geometry value inside the cache-type word
    localparam int GEOM_HI_POS = 18;
    localparam int GEOM_LO_POS = 6;

    typedef enum logic [3:0] {
        RG_ID, RG_TYPE, RG_CTRL, RG_AUX, RG_TAG, RG_DATA,
        RG_FSTART, RG_FEND, RG_MAINT, RG_QUIET, RG_NONE
    } region_e;

    typedef struct packed {
        word_t ctrl;
        word_t aux;
        word_t tag_lat;
        word_t data_lat;
        word_t fstart;
        word_t fend;
    } cfg_t;

    function automatic region_e decode_ofs(ofs_t o);
        region_e r;
        if (o >= MAINT_LO && o < MAINT_HI) begin
            r = RG_MAINT;
        end else begin
            case (o)
                OFS_ID:     r = RG_ID;
                OFS_TYPE:   r = RG_TYPE;
                OFS_CTRL:   r = RG_CTRL;
                OFS_AUX:    r = RG_AUX;
                OFS_TAG:    r = RG_TAG;
                OFS_DATA:   r = RG_DATA;
                OFS_FSTART: r = RG_FSTART;
                OFS_FEND:   r = RG_FEND;
                OFS_QUIET0, OFS_QUIET1, OFS_QUIET2: r = RG_QUIET;
                default:    r = RG_NONE;
            endcase
        end
        return r;
    endfunction

    // geom = aux[19:16]; result places aux[19:17] at 4:2 and aux[16] at 0
    function automatic logic [4:0] geom_value(logic [3:0] geom);
        return {geom[3:1], 1'b0, geom[0]};
    endfunction

    function automatic logic write_ok(region_e r);
        return !(r == RG_NONE || r == RG_ID || r == RG_TYPE);
    endfunction

endpackage

// File: rtl/ccstub_decode.sv
module ccstub_decode
    import ccstub_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    output region_e           region,
    output logic              bad
);
    generate
        if (ADDR_W > OFS_W) begin : g_alias
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:OFS_W];
        end
    endgenerate

    always_comb begin
        region = decode_ofs(addr[OFS_W-1:0]);
        bad    = (rd_en && region == RG_NONE) || (wr_en && !write_ok(region));
    end
endmodule

// File: rtl/ccstub_cfg.sv
module ccstub_cfg
    import ccstub_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  region_e region,
    input  word_t   wr_data,
    output cfg_t    cfg
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q          <= '0;
            cfg_q.aux      <= AUX_RESET;
        end else if (wr_en) begin
            case (region)
                RG_CTRL:   cfg_q.ctrl     <= {{(WORD_W-1){1'b0}}, wr_data[0]};
                RG_AUX:    cfg_q.aux      <= wr_data;
                RG_TAG:    cfg_q.tag_lat  <= wr_data;
                RG_DATA:   cfg_q.data_lat <= wr_data;
                RG_FSTART: cfg_q.fstart   <= wr_data;
                RG_FEND:   cfg_q.fend     <= wr_data;
                default:   ;
            endcase
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/ccstub_typeword.sv
module ccstub_typeword
    import ccstub_pkg::*;
#(
    parameter word_t TYPE_INIT = 32'h1C100100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_hit,
    input  logic [3:0] geom,
    output word_t      type_val
);
    word_t type_q;
    word_t type_next;
    word_t geom_w;

    always_comb begin
        geom_w    = word_t'(geom_value(geom));
        type_next = type_q | (geom_w << GEOM_HI_POS) | (geom_w << GEOM_LO_POS);
    end

    always_ff @(posedge clk) begin
        if (rst)         type_q <= TYPE_INIT;
        else if (rd_hit) type_q <= type_next;
    end

    assign type_val = type_next;
endmodule

// File: rtl/ccstub_top.sv
module ccstub_top
    import ccstub_pkg::*;
#(
    parameter int    ADDR_W    = 32,
    parameter word_t TYPE_INIT = 32'h1C100100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              bad_access
);
    region_e region;
    logic    bad_now;
    cfg_t    cfg;
    word_t   type_val;
    word_t   rd_mux;

    ccstub_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (addr),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .region (region),
        .bad    (bad_now)
    );

    ccstub_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .region  (region),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    ccstub_typeword #(.TYPE_INIT(TYPE_INIT)) u_type (
        .clk      (clk),
        .rst      (rst),
        .rd_hit   (rd_en && region == RG_TYPE),
        .geom     (cfg.aux[19:16]),
        .type_val (type_val)
    );

    always_comb begin
        case (region)
            RG_ID:     rd_mux = ID_WORD;
            RG_TYPE:   rd_mux = type_val;
            RG_CTRL:   rd_mux = cfg.ctrl;
            RG_AUX:    rd_mux = cfg.aux;
            RG_TAG:    rd_mux = cfg.tag_lat;
            RG_DATA:   rd_mux = cfg.data_lat;
            RG_FSTART: rd_mux = cfg.fstart;
            RG_FEND:   rd_mux = cfg.fend;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data    <= '0;
            bad_access <= 1'b0;
        end else begin
            rd_data    <= rd_en ? rd_mux : '0;
            bad_access <= bad_now;
        end
    end
endmodule

// File: rtl/ccstub_chk.sv
module ccstub_chk
    import ccstub_pkg::*;
#(
    parameter int    ADDR_W    = 32,
    parameter word_t TYPE_INIT = 32'h1C100100
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [31:0]       rd_data,
    input logic              bad_access
);
    ofs_t  ofs;
    logic  in_maint;
    logic  type_rd_d;
    word_t last_type;

    assign ofs      = addr[OFS_W-1:0];
    assign in_maint = (ofs >= 12'h730) && (ofs < 12'h800);

    always_ff @(posedge clk) begin
        if (rst) begin
            type_rd_d <= 1'b0;
            last_type <= TYPE_INIT;
        end else begin
            type_rd_d <= rd_en && ofs == 12'h004;
            if (type_rd_d) last_type <= rd_data;
        end
    end

    assert_id_word_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && ofs == 12'h000) |=> rd_data == 32'h410000C8);

    assert_ctrl_bit0_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && ofs == 12'h100) |=> rd_data[31:1] == '0);

    assert_maint_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && in_maint) |=> (rd_data == '0 && !bad_access));

    assert_type_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        type_rd_d |-> ((rd_data & last_type) == last_type));

    assert_bad_needs_access_R9: assert property (@(posedge clk) disable iff (rst)
        !(rd_en || wr_en) |=> !bad_access);

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rd_data == '0);
endmodule

bind ccstub_top ccstub_chk #(.ADDR_W(ADDR_W), .TYPE_INIT(TYPE_INIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .bad_access (bad_access)
);

// File: tb/ccstub_top_tb.sv
module ccstub_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        bad_access;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    ccstub_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .bad_access (bad_access)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // drive at negedge, commit at posedge, observe at following negedge
    task automatic do_write(input logic [31:0] a, input logic [31:0] d, output logic bad);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        bad = bad_access;
    endtask

    task automatic do_read(input logic [31:0] a, output logic [31:0] d, output logic bad);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
        bad = bad_access;
    endtask

    task automatic expect_read(input string req, input logic [31:0] a,
                               input logic [31:0] exp, input logic exp_bad);
        logic [31:0] d; logic b;
        do_read(a, d, b);
        check(req, d, exp);
        check({req, " err"}, {31'b0, b}, {31'b0, exp_bad});
    endtask

    task automatic expect_write(input string req, input logic [31:0] a,
                                input logic [31:0] d, input logic exp_bad);
        logic b;
        do_write(a, d, b);
        check({req, " wr err"}, {31'b0, b}, {31'b0, exp_bad});
    endtask

    task automatic t_reset;   // R4
        expect_read("R4 ctrl",   32'h100, 32'h0, 1'b0);
        expect_read("R4 aux",    32'h104, 32'h02020000, 1'b0);
        expect_read("R4 tag",    32'h108, 32'h0, 1'b0);
        expect_read("R4 data",   32'h10C, 32'h0, 1'b0);
        expect_read("R4 fstart", 32'hC00, 32'h0, 1'b0);
        expect_read("R4 fend",   32'hC04, 32'h0, 1'b0);
    endtask

    task automatic t_timing;  // R11
        @(negedge clk);
        check("R11 idle rd_data", rd_data, 32'h0);
        @(negedge clk);
        addr = 32'h104; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R11 data next cycle", rd_data, 32'h02020000);
        @(negedge clk);
        check("R11 zero after read", rd_data, 32'h0);
    endtask

    task automatic t_id;      // R1, R9
        expect_read("R1 id", 32'h000, 32'h410000C8, 1'b0);
        expect_write("R9 write id", 32'h000, 32'hFFFFFFFF, 1'b1);
        expect_read("R1 id after write", 32'h000, 32'h410000C8, 1'b0);
    endtask

    task automatic t_ctrl;    // R2
        expect_write("R2", 32'h100, 32'hFFFFFFFF, 1'b0);
        expect_read("R2 all ones", 32'h100, 32'h1, 1'b0);
        expect_write("R2", 32'h100, 32'hFFFFFFFE, 1'b0);
        expect_read("R2 bit0 clear", 32'h100, 32'h0, 1'b0);
    endtask

    task automatic t_full;    // R3
        logic [31:0] offs [5] = '{32'h104, 32'h108, 32'h10C, 32'hC00, 32'hC04};
        for (int i = 0; i < 5; i++) begin
            expect_write("R3", offs[i], 32'hA5A50000 ^ (32'h1111 * (i + 1)), 1'b0);
        end
        for (int i = 0; i < 5; i++) begin
            expect_read("R3 pattern", offs[i], 32'hA5A50000 ^ (32'h1111 * (i + 1)), 1'b0);
        end
        expect_write("R3", 32'hC04, 32'hFFFFFFFF, 1'b0);
        expect_read("R3 ones", 32'hC04, 32'hFFFFFFFF, 1'b0);
    endtask

    task automatic t_maint;   // R5, R9 bounds
        expect_read("R5 low edge", 32'h730, 32'h0, 1'b0);
        expect_read("R5 high edge", 32'h7FC, 32'h0, 1'b0);
        expect_write("R5 write", 32'h740, 32'hFFFFFFFF, 1'b0);
        expect_read("R9 below window", 32'h72C, 32'h0, 1'b1);
        expect_read("R9 above window", 32'h800, 32'h0, 1'b1);
        expect_read("R5 fend untouched", 32'hC04, 32'hFFFFFFFF, 1'b0);
    endtask

    task automatic t_quiet;   // R8
        expect_read("R8 f40", 32'hF40, 32'h0, 1'b0);
        expect_read("R8 f60", 32'hF60, 32'h0, 1'b0);
        expect_write("R8 f80", 32'hF80, 32'h12345678, 1'b0);
        expect_read("R8 f80", 32'hF80, 32'h0, 1'b0);
    endtask

    task automatic t_unknown; // R9
        expect_write("R9 unknown write", 32'h200, 32'hDEADBEEF, 1'b1);
        @(negedge clk);
        check("R9 pulse one cycle", {31'b0, bad_access}, 32'h0);
        expect_read("R9 unknown read", 32'h200, 32'h0, 1'b1);
        expect_write("R9 write type", 32'h004, 32'h0, 1'b1);
    endtask

    task automatic t_alias;   // R10
        expect_write("R10", 32'hABCD5108, 32'h00C0FFEE, 1'b0);
        expect_read("R10 alias", 32'h00000108, 32'h00C0FFEE, 1'b0);
        expect_read("R10 alias id", 32'hFFFFF000, 32'h410000C8, 1'b0);
    endtask

    task automatic t_type;    // R6, R7
        expect_write("R6", 32'h104, 32'h02020000, 1'b0);
        expect_read("R6 reset aux", 32'h004, 32'h1C100100, 1'b0);
        expect_write("R6", 32'h104, 32'h00090000, 1'b0);
        expect_read("R6 bits 19 and 16", 32'h004, 32'h1C540540, 1'b0);
        expect_write("R7", 32'h104, 32'h0, 1'b0);
        expect_read("R7 sticky", 32'h004, 32'h1C540540, 1'b0);
        expect_write("R6", 32'h104, 32'h000E0000, 1'b0);
        expect_read("R6 assoc bits", 32'h004, 32'h1C740740, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_timing();
        t_id();
        t_ctrl();
        t_full();
        t_maint();
        t_quiet();
        t_unknown();
        t_alias();
        t_type();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule